// File: doc/BRIEF.md
# Dual-Channel Serial Output Shifter

This block is the digital output stage of a two-channel simultaneous-sampling converter. Two 12-bit conversion results come in on a parallel valid/ready port, and the block shifts them out one bit per serial-clock slot. The serial clock and the conversion-start strobe both come from outside the block. They are sampled by the block's own system clock, and their edges are found from those samples.

The block has two modes. In dual mode each channel has its own data pin and the frame is 16 slots long. In single mode both results go out one after the other on the first pin over 28 slots. In both modes the first four slots carry zeros and the data goes out most significant bit first. When the last slot of a frame ends, the block reads the level of the conversion-start input. If it is high, a new frame begins at once and the pins stay driven. If it is low, the block enters power-down. It then releases the pins (output enable low) on the next rising edge of either the serial clock or the conversion-start input, whichever comes first.

The input port uses valid/ready handshaking. `res_ready` is high while a one-entry staging register is empty, and a result is taken on any clock where both `res_valid` and `res_ready` are high. While the register is full, the upstream side must hold its data. The staged result moves into the shifters only when a frame starts, and that empties the register.

Top module: `dual_serial_shifter`

## Requirements
- R1: After reset, `oe_a`, `oe_b`, `pwr_down` and `conv_start` are low and `res_ready` is high.
- R2: A rising edge on `cnvst` while no frame is running gives exactly one clock of `conv_start` and starts a frame with its slot count at zero. A rising edge on `cnvst` while a frame is running is ignored.
- R3: In dual mode, after the k-th rising edge of `sclk` in a frame, `dout_a` carries result A and `dout_b` carries result B. Slots 1 to 4 are 0, and slots 5 to 16 carry bits 11 down to 0.
- R4: In single mode, `dout_a` carries 0 in slots 1 to 4, bits 11..0 of A in slots 5 to 16, and bits 11..0 of B in slots 17 to 28. `oe_b` stays low.
- R5: The output enables are low between a frame start from the idle or power-down state and the frame's first `sclk` rising edge. From that edge on they are high: `oe_a` always, and `oe_b` in dual mode only.
- R6: The decision point is the `sclk` falling edge after the 16th rising edge (dual mode) or after the 28th (single mode). If `cnvst` is high there, a new frame starts at once: `conv_start` pulses, the enables stay high and `pwr_down` stays low.
- R7: If `cnvst` is low at the decision point, `pwr_down` goes high while the enables stay high.
- R8: In that state, the next `sclk` rising edge drops both enables and `pwr_down` stays high.
- R9: In that state, a `cnvst` rising edge drops both enables, clears `pwr_down` and starts a new frame.
- R10: `res_ready` is high exactly when the staging register is empty. A frame start loads the staged result and empties the register. A frame that starts with nothing staged shifts out zeros.
- R11: A result accepted while a frame is running does not change that frame's bits. It is used by the next frame.
- R12: `dual_mode` is sampled only at frame start. Changing it mid-frame changes neither the frame length nor the pin use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to sample `sclk` and `cnvst` |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | External serial clock |
| cnvst | input | 1 | Conversion-start strobe, level-sensitive at the decision point |
| dual_mode | input | 1 | 1 = one pin per channel, 0 = both channels on `dout_a` |
| res_valid | input | 1 | Result pair offered |
| res_ready | output | 1 | Staging register empty, ready to accept |
| res_a | input | 12 | Channel A result |
| res_b | input | 12 | Channel B result |
| dout_a | output | 1 | Serial data, pin A |
| dout_b | output | 1 | Serial data, pin B (dual mode) |
| oe_a | output | 1 | Output enable for pin A (low = high-impedance) |
| oe_b | output | 1 | Output enable for pin B (low = high-impedance) |
| conv_start | output | 1 | One-clock pulse at each frame start |
| pwr_down | output | 1 | High from a low-`cnvst` decision until the next frame start |

## Verification
A table of result pairs is shifted out in both modes. The values are chosen so that mode, bit order and channel routing each give a distinct bit pattern: alternating nibbles, all-ones against a lone low bit, and a single MSB against its complement. Successive frames alternate between releasing the pins by a serial-clock edge and by a strobe edge, so the two release paths are told apart. A continuous run raises the strobe mid-frame and stages a new result during the frame. This separates an ignored mid-frame edge and undisturbed bits from the continuation decision and the reload. A final frame starts with nothing staged and flips the mode input mid-frame, which shows that the zero fill and the mode latched at frame start both hold.

// File: rtl/dsos_pkg.sv
package dsos_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PEND   = 2'd2,
    ST_PDOWN  = 2'd3
  } fr_state_e;
endpackage

// File: rtl/dsos_edge.sv
module dsos_edge #(
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic lvl_s,
  output logic rise,
  output logic fall
);
  logic prev;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign lvl_s = lvl;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '0;
        end else begin
          chain[0] <= lvl;
          for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign lvl_s = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl_s;
  end

  assign rise = lvl_s & ~prev;
  assign fall = ~lvl_s & prev;
endmodule

// File: rtl/dsos_stage.sv
module dsos_stage #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [RES_W-1:0] in_a,
  input  logic [RES_W-1:0] in_b,
  input  logic             take,
  output logic [RES_W-1:0] out_a,
  output logic [RES_W-1:0] out_b
);
  logic             full;
  logic [RES_W-1:0] da, db;

  assign in_ready = ~full;
  assign out_a    = full ? da : '0;
  assign out_b    = full ? db : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      da   <= '0;
      db   <= '0;
    end else begin
      if (take) full <= 1'b0;
      if (in_valid && in_ready) begin
        full <= 1'b1;
        da   <= in_a;
        db   <= in_b;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(da) && $stable(db)));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !take) |=> !in_ready);
endmodule

// File: rtl/dsos_shift.sv
module dsos_shift #(
  parameter int RES_W = 12,
  parameter int LEAD  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift_en,
  input  logic             dual_mode,
  input  logic [RES_W-1:0] a,
  input  logic [RES_W-1:0] b,
  output logic             dout_a,
  output logic             dout_b
);
  localparam int SA_W = 2*RES_W + LEAD;
  localparam int SB_W = RES_W + LEAD;
  localparam int CW   = $clog2(SA_W + 1);

  logic [SA_W-1:0] sr_a;
  logic [SB_W-1:0] sr_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_a   <= '0;
      sr_b   <= '0;
      dout_a <= 1'b0;
      dout_b <= 1'b0;
    end else if (load) begin
      sr_a <= dual_mode ? {{LEAD{1'b0}}, a, {RES_W{1'b0}}}
                        : {{LEAD{1'b0}}, a, b};
      sr_b <= dual_mode ? {{LEAD{1'b0}}, b} : '0;
    end else if (shift_en) begin
      dout_a <= sr_a[SA_W-1];
      dout_b <= sr_b[SB_W-1];
      sr_a   <= sr_a << 1;
      sr_b   <= sr_b << 1;
    end
  end

  // count of shifts since the last load, used to check the zero lead-in
  logic [CW-1:0] shifts_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 shifts_seen <= '0;
    else if (load)                              shifts_seen <= '0;
    else if (shift_en && shifts_seen < CW'(SA_W)) shifts_seen <= shifts_seen + 1'b1;
  end

  p_lead_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load && shifts_seen < CW'(LEAD)) |=> (!dout_a && !dout_b));
endmodule

// File: rtl/dsos_ctrl.sv
module dsos_ctrl
  import dsos_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int LEAD  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_rise,
  input  logic sclk_fall,
  input  logic cnv_rise,
  input  logic cnv_lvl,
  input  logic dual_mode,
  output logic start,
  output logic shift_en,
  output logic oe,
  output logic oe_dual,
  output logic pwr_down,
  output logic conv_start
);
  localparam int N_DUAL   = RES_W + LEAD;
  localparam int N_SINGLE = 2*RES_W + LEAD;
  localparam int CNT_W    = $clog2(N_SINGLE + 1);

  fr_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] n_end;
  logic             mode_q;
  logic             in_frame;
  logic             decide;

  assign n_end    = mode_q ? CNT_W'(N_DUAL) : CNT_W'(N_SINGLE);
  assign in_frame = (state == ST_ACTIVE);
  assign shift_en = in_frame & sclk_rise & (cnt < n_end);
  assign decide   = in_frame & sclk_fall & (cnt == n_end);
  assign start    = (cnv_rise & ~in_frame) | (decide & cnv_lvl);
  assign oe_dual  = oe & mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      mode_q     <= 1'b0;
      oe         <= 1'b0;
      pwr_down   <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= start;
      if (start) begin
        state    <= ST_ACTIVE;
        cnt      <= '0;
        mode_q   <= dual_mode;
        pwr_down <= 1'b0;
        if (state == ST_PEND) oe <= 1'b0;
      end else if (decide) begin
        state    <= ST_PEND;
        pwr_down <= 1'b1;
      end else begin
        if (shift_en) begin
          cnt <= cnt + 1'b1;
          oe  <= 1'b1;
        end
        if (state == ST_PEND && sclk_rise) begin
          state <= ST_PDOWN;
          oe    <= 1'b0;
        end
      end
    end
  end

  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_ignore_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && cnv_rise && !decide) |=> !conv_start);

  p_cont_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && cnv_lvl) |=> (conv_start && !pwr_down && $stable(oe)));

  p_pd_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> oe);

  p_sclk_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PEND && sclk_rise) |=> (!oe && pwr_down));

  p_cnv_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PEND && cnv_rise) |=> (!oe && conv_start && !pwr_down));

  p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= n_end);
endmodule

// File: rtl/dual_serial_shifter.sv
module dual_serial_shifter #(
  parameter int RES_W       = 12,
  parameter int LEAD        = 4,
  parameter int SYNC_STAGES = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cnvst,
  input  logic             dual_mode,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  output logic             dout_a,
  output logic             dout_b,
  output logic             oe_a,
  output logic             oe_b,
  output logic             conv_start,
  output logic             pwr_down
);
  logic sclk_s, sclk_rise, sclk_fall;
  logic cnv_s, cnv_rise, cnv_fall;
  logic start, shift_en;
  logic [RES_W-1:0] ld_a, ld_b;

  dsos_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sclk),
    .lvl_s(sclk_s), .rise(sclk_rise), .fall(sclk_fall)
  );

  dsos_edge #(.SYNC_STAGES(SYNC_STAGES)) u_cnv_edge (
    .clk(clk), .rst_n(rst_n), .lvl(cnvst),
    .lvl_s(cnv_s), .rise(cnv_rise), .fall(cnv_fall)
  );

  dsos_stage #(.RES_W(RES_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(res_valid), .in_ready(res_ready),
    .in_a(res_a), .in_b(res_b),
    .take(start), .out_a(ld_a), .out_b(ld_b)
  );

  dsos_ctrl #(.RES_W(RES_W), .LEAD(LEAD)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cnv_rise(cnv_rise), .cnv_lvl(cnv_s),
    .dual_mode(dual_mode),
    .start(start), .shift_en(shift_en),
    .oe(oe_a), .oe_dual(oe_b),
    .pwr_down(pwr_down), .conv_start(conv_start)
  );

  dsos_shift #(.RES_W(RES_W), .LEAD(LEAD)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(start), .shift_en(shift_en), .dual_mode(dual_mode),
    .a(ld_a), .b(ld_b),
    .dout_a(dout_a), .dout_b(dout_b)
  );

  p_oe_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_b |-> oe_a);

  p_start_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !pwr_down);

  logic unused_fall;
  assign unused_fall = cnv_fall;
endmodule

// File: tb/dual_serial_shifter_bench.sv
module dual_serial_shifter_bench;
  localparam int LEAD = 4;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cnvst = 1'b0;
  logic dual_mode = 1'b1, res_valid = 1'b0;
  logic [11:0] res_a = '0, res_b = '0;
  logic res_ready, dout_a, dout_b, oe_a, oe_b, conv_start, pwr_down;

  int checks = 0, errors = 0;
  logic [28:1] cap_a, cap_b, cap_oa, cap_ob;
  logic end_cs, end_pd, mid_cs;

  // {dual, A, B}
  localparam logic [24:0] VEC [4] = '{
    {1'b1, 12'hA5C, 12'h3F1},
    {1'b0, 12'hFFF, 12'h001},
    {1'b1, 12'h800, 12'h7FF},
    {1'b0, 12'h123, 12'hABC}
  };

  always #4 clk = ~clk;

  dual_serial_shifter u_dual_serial_shifter (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cnvst(cnvst),
    .dual_mode(dual_mode), .res_valid(res_valid), .res_ready(res_ready),
    .res_a(res_a), .res_b(res_b), .dout_a(dout_a), .dout_b(dout_b),
    .oe_a(oe_a), .oe_b(oe_b), .conv_start(conv_start), .pwr_down(pwr_down)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_a(logic [11:0] a, logic [11:0] b, int s);
    if (s <= LEAD) return 1'b0;
    if (s <= 16)   return a[16-s];
    return b[28-s];
  endfunction

  function automatic logic exp_b(bit dual, logic [11:0] b, int s);
    if (!dual || s <= LEAD) return 1'b0;
    return b[16-s];
  endfunction

  task automatic stage(logic [11:0] a, logic [11:0] b);
    res_a = a; res_b = b; res_valid = 1'b1;
    tick(1);
    res_valid = 1'b0;
  endtask

  task automatic start_frame(output bit cs_now, output bit cs_next, output bit oe_after);
    cnvst = 1'b1;
    tick(1);
    cs_now = conv_start;
    oe_after = oe_a;
    tick(1);
    cs_next = conv_start;
  endtask

  task automatic run_frame(int n, int cnv_slot);
    cap_a = '0; cap_b = '0; cap_oa = '0; cap_ob = '0;
    mid_cs = 1'b0; end_cs = 1'b0;
    for (int s = 1; s <= n; s++) begin
      sclk = 1'b1;
      tick(1);
      cap_a[s] = dout_a; cap_b[s] = dout_b; cap_oa[s] = oe_a; cap_ob[s] = oe_b;
      if (conv_start) mid_cs = 1'b1;
      tick(3);
      if (s == cnv_slot) cnvst = 1'b1;
      sclk = 1'b0;
      tick(1);
      if (s == n) end_cs = conv_start;
      else if (conv_start) mid_cs = 1'b1;
      tick(3);
    end
    end_pd = pwr_down;
  endtask

  task automatic check_frame(bit dual, logic [11:0] a, logic [11:0] b, string ctx);
    logic [28:1] ea, eb, eo, eob;
    int n;
    n = dual ? 16 : 28;
    ea = '0; eb = '0; eo = '0; eob = '0;
    for (int s = 1; s <= n; s++) begin
      ea[s] = exp_a(a, b, s);
      eb[s] = exp_b(dual, b, s);
      eo[s] = 1'b1;
      eob[s] = dual;
    end
    chk(cap_a == ea, dual ? {"R3 dout_a ", ctx} : {"R4 dout_a ", ctx}, 32'(cap_a), 32'(ea));
    chk(cap_b == eb, dual ? {"R3 dout_b ", ctx} : {"R4 dout_b ", ctx}, 32'(cap_b), 32'(eb));
    chk(cap_oa == eo, {"R5 oe_a per slot ", ctx}, 32'(cap_oa), 32'(eo));
    chk(cap_ob == eob, dual ? {"R5 oe_b per slot ", ctx} : {"R4 oe_b low ", ctx},
        32'(cap_ob), 32'(eob));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    bit c1, c2, oe_st;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk(!oe_a && !oe_b, "R1 enables low after reset", {oe_a, oe_b}, 0);
    chk(!pwr_down && !conv_start, "R1 flags low after reset", {pwr_down, conv_start}, 0);
    chk(res_ready, "R1 ready high after reset", res_ready, 1);

    // table walk: alternate release by SCLK (even) and by CNVST (odd previous)
    for (int i = 0; i < 4; i++) begin
      bit d;
      logic [11:0] a, b;
      {d, a, b} = VEC[i];
      dual_mode = d;
      chk(res_ready, "R10 ready while empty", res_ready, 1);
      stage(a, b);
      chk(!res_ready, "R10 ready low while held", res_ready, 0);
      if (i == 2) chk(oe_a && pwr_down, "R7 pending keeps pins driven", {oe_a, pwr_down}, 3);
      start_frame(c1, c2, oe_st);
      chk(c1 && !c2, "R2 conv_start single pulse", {c1, c2}, 2);
      chk(!oe_st, (i == 2) ? "R9 CNVST edge releases pins" : "R5 oe low before first SCLK",
          oe_st, 0);
      chk(res_ready, "R10 stage emptied at frame start", res_ready, 1);
      cnvst = 1'b0;
      tick(2);
      run_frame(d ? 16 : 28, 0);
      check_frame(d, a, b, "table");
      chk(end_pd && oe_a, "R7 low CNVST at decision powers down", {end_pd, oe_a}, 3);
      if (i % 2 == 0) begin
        sclk = 1'b1;
        tick(1);
        chk(!oe_a && !oe_b && pwr_down, "R8 SCLK edge releases pins",
            {oe_a, oe_b, pwr_down}, 1);
        tick(3);
        sclk = 1'b0;
        tick(4);
      end
    end

    // continuous run in dual mode; last table frame left the block pending
    dual_mode = 1'b1;
    chk(oe_a && pwr_down, "R7 pins held before CNVST", {oe_a, pwr_down}, 3);
    stage(12'hC3A, 12'h15E);
    start_frame(c1, c2, oe_st);
    chk(!oe_st && c1 && !pwr_down, "R9 CNVST edge releases and restarts",
        {oe_st, c1, pwr_down}, 2);
    cnvst = 1'b0;
    tick(2);
    chk(res_ready, "R11 ready during frame", res_ready, 1);
    stage(12'h0F0, 12'hE07);
    run_frame(16, 14);
    check_frame(1'b1, 12'hC3A, 12'h15E, "R11 bits in flight");
    chk(!mid_cs, "R2 CNVST edge mid-frame ignored", mid_cs, 0);
    chk(end_cs && !end_pd && oe_a, "R6 continuous restart", {end_cs, end_pd, oe_a}, 5);
    cnvst = 1'b0;
    tick(2);
    run_frame(16, 0);
    check_frame(1'b1, 12'h0F0, 12'hE07, "R10 staged result used");
    chk(end_pd, "R7 power-down after continuous pair", end_pd, 1);

    // empty stage, mode flipped mid-frame
    start_frame(c1, c2, oe_st);
    chk(c1 && !oe_st, "R9 restart from pending", {c1, oe_st}, 2);
    cnvst = 1'b0;
    tick(2);
    dual_mode = 1'b0;
    run_frame(16, 0);
    check_frame(1'b1, 12'h000, 12'h000, "R10 R12 zero fill, mode latched");
    chk(end_pd, "R12 frame ends at 16th edge despite mode flip", end_pd, 1);

    finish_run();
  end
endmodule